// File: doc/BRIEF.md
# Grid Phase and Amplitude Tracker

This block closes the synchronous-frame tracking loop of a three-phase grid synchronizer. It receives the d and q components after the upstream delayed-cancellation filter and turns each such pair into a phase error. A four-quadrant arctangent of q over d gives that error directly, with no small-angle approximation. The arctangent runs as an iterative CORDIC vectoring engine at one micro-rotation per clock. A proportional-integral controller turns the error into a frequency estimate around the nominal 50 Hz. A phase accumulator integrates that frequency into the estimated grid angle.

The upstream filter scales the fundamental by sin(π/n) and adds a phase lead of π/2 − π/n, where n is its delay factor. Two compensated outputs undo both effects. The amplitude is the filtered d multiplied by a precomputed reciprocal of sin(π/n). The corrected angle is the oscillator angle plus the constant π/n − π/2. Angles are 32-bit phase words in which 2^32 stands for a full turn. Frequency is a signed phase increment per sample.

Top module: `grid_sync_estimator`

## Requirements
- R1: While reset is asserted and after it is released, `angle` is 0, `freq` equals the nominal increment NOM = floor(50·2^32/SAMPLE_HZ), `angle_corr` equals the correction constant CORR, `amplitude` is 0, and `est_valid` is 0.
- R2: The phase error is the four-quadrant arctangent of (q, d), expressed in phase-word units as a signed 32-bit value, for input vectors in every quadrant.
- R3: On each update, `freq` = NOM + I + floor(e·KP_Q / 2^KP_SHIFT). Here e is the phase error, and I is the integrator after it adds floor(e·KI_Q / 2^KI_SHIFT).
- R4: The integrator is clamped to ±LIM, with LIM = floor(FDEV_HZ·2^32/SAMPLE_HZ) (10 Hz of deviation), so a sustained error drives `freq` to NOM ± LIM plus the proportional term.
- R5: On each update, `angle` advances by the new `freq` modulo 2^32 and wraps through zero with no other effect.
- R6: `angle_corr` always equals `angle` + CORR modulo 2^32, with CORR = floor(2^32/(2n)) − 2^30 (the lag π/n − π/2).
- R7: `amplitude` = floor(d·AMP_RECIP / 2^AMP_SHIFT), where d is the `d_in` of the accepted sample.
- R8: `est_valid` is a one-cycle pulse that rises exactly ITER+1 clock edges after the edge that accepted the sample.
- R9: A `sample_valid` strobe that arrives while a conversion is in progress is ignored: it produces no result pulse and does not alter any output.
- R10: Between update pulses, `angle`, `angle_corr`, `freq` and `amplitude` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Strobe marking a new filtered d/q pair |
| d_in | input | DW | Filtered d component, signed |
| q_in | input | DW | Filtered q component, signed |
| est_valid | output | 1 | One-cycle pulse when the outputs update |
| angle | output | 32 | Oscillator angle, 2^32 = one turn |
| angle_corr | output | 32 | Angle with the filter phase lead removed |
| freq | output | 32 | Signed phase increment per sample |
| amplitude | output | DW+4 | Compensated grid amplitude, signed |

## Verification
The assertions take for granted that reset is held for at least one edge before the first sample. They also rely on the fact that a conversion, once started, always finishes without outside help. They make no assumption about how often strobes arrive. The stimulus keeps input vectors well away from the origin, so that quantisation does not dominate the arctangent. It also never puts a vector exactly on the negative d axis, where +π and −π are the same phase word and a reference value cannot pick a sign. Extra strobes are fired only inside the busy window, to exercise the ignore rule.

// File: rtl/gse_pkg.sv
package gse_pkg;
   localparam int PHASE_W = 32;
   typedef logic [PHASE_W-1:0] phase_t;
   localparam phase_t PHASE_HALF = 32'h8000_0000;

   // arctangent of 2^-idx as a fraction of a full turn scaled by 2^32
   function automatic phase_t atan_step(input int idx);
      case (idx)
         0:  atan_step = 32'd536870912;
         1:  atan_step = 32'd316933406;
         2:  atan_step = 32'd167458907;
         3:  atan_step = 32'd85004756;
         4:  atan_step = 32'd42667331;
         5:  atan_step = 32'd21354465;
         6:  atan_step = 32'd10679838;
         7:  atan_step = 32'd5340245;
         8:  atan_step = 32'd2670163;
         9:  atan_step = 32'd1335087;
         10: atan_step = 32'd667544;
         11: atan_step = 32'd333772;
         12: atan_step = 32'd166886;
         13: atan_step = 32'd83443;
         14: atan_step = 32'd41722;
         default: atan_step = phase_t'(20861 >> (idx - 15));
      endcase
   endfunction
endpackage

// File: rtl/gse_cordic_vec.sv
module gse_cordic_vec
   import gse_pkg::*;
#(
   parameter int DW   = 16,
   parameter int ITER = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic signed [DW-1:0] x_in,
   input  logic signed [DW-1:0] y_in,
   output logic                 busy,
   output logic                 done,
   output phase_t               z_out
);
   localparam int GB = 4;
   localparam int XW = DW + 2 + GB;
   localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

   if (ITER < 4 || ITER > 30) begin : g_bad_iter
      $error("gse_cordic_vec: ITER out of range");
   end

   logic signed [XW-1:0] x_q, y_q, x_ext, y_ext, x_sh, y_sh;
   logic [CW-1:0]        it_q;
   phase_t               z_q;

   always_comb begin
      x_ext = {{(XW-DW-GB){x_in[DW-1]}}, x_in, {GB{1'b0}}};
      y_ext = {{(XW-DW-GB){y_in[DW-1]}}, y_in, {GB{1'b0}}};
      x_sh  = x_q >>> it_q;
      y_sh  = y_q >>> it_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         done <= 1'b0;
         it_q <= '0;
         x_q  <= '0;
         y_q  <= '0;
         z_q  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               it_q <= '0;
               // left half-plane: turn by a half revolution first
               if (x_in[DW-1]) begin
                  x_q <= -x_ext;
                  y_q <= -y_ext;
                  z_q <= PHASE_HALF;
               end else begin
                  x_q <= x_ext;
                  y_q <= y_ext;
                  z_q <= '0;
               end
            end
         end else begin
            if (!y_q[XW-1]) begin
               x_q <= x_q + y_sh;
               y_q <= y_q - x_sh;
               z_q <= z_q + atan_step(int'(it_q));
            end else begin
               x_q <= x_q - y_sh;
               y_q <= y_q + x_sh;
               z_q <= z_q - atan_step(int'(it_q));
            end
            if (it_q == CW'(ITER-1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               it_q <= it_q + CW'(1);
            end
         end
      end
   end

   assign z_out = z_q;

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(busy)); // R8
   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start)); // R9
endmodule

// File: rtl/gse_pi_ctrl.sv
module gse_pi_ctrl #(
   parameter int NOM      = 21474836,
   parameter int LIM      = 4294967,
   parameter int KP_Q     = 3257,
   parameter int KP_SHIFT = 16,
   parameter int KI_Q     = 17169,
   parameter int KI_SHIFT = 24
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic signed [31:0] err,
   output logic signed [31:0] freq_next,
   output logic signed [31:0] freq
);
   if (LIM <= 0 || KP_SHIFT > 40 || KI_SHIFT > 40) begin : g_bad_gain
      $error("gse_pi_ctrl: gain or limit parameters out of range");
   end

   logic signed [31:0] integ_q, integ_n, prop, istep;
   logic signed [32:0] isum;

   always_comb begin
      prop  = 32'((longint'(err) * longint'(KP_Q)) >>> KP_SHIFT);
      istep = 32'((longint'(err) * longint'(KI_Q)) >>> KI_SHIFT);
      isum  = 33'(integ_q) + 33'(istep);
      if (longint'(isum) > longint'(LIM))
         integ_n = 32'(LIM);
      else if (longint'(isum) < -longint'(LIM))
         integ_n = -32'(LIM);
      else
         integ_n = 32'(isum);
      freq_next = 32'(NOM) + integ_n + prop;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         integ_q <= '0;
         freq    <= 32'(NOM);
      end else if (upd) begin
         integ_q <= integ_n;
         freq    <= freq_next;
      end
   end

   AST_INTEG_LIMIT: assert property (@(posedge clk) disable iff (rst)
      (integ_q <= LIM) && (integ_q >= -LIM)); // R4
   AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(freq)); // R10
endmodule

// File: rtl/gse_phase_acc.sv
module gse_phase_acc
   import gse_pkg::*;
#(
   parameter phase_t CORR = 32'd0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic signed [31:0] step,
   output phase_t             angle,
   output phase_t             angle_corr
);
   phase_t angle_n;
   assign angle_n = angle + phase_t'(step);

   always_ff @(posedge clk) begin
      if (rst) begin
         angle      <= '0;
         angle_corr <= CORR;
      end else if (upd) begin
         angle      <= angle_n;
         angle_corr <= angle_n + CORR;
      end
   end

   AST_CORR_OFFSET: assert property (@(posedge clk) disable iff (rst)
      (angle_corr - angle) == CORR); // R6
   AST_ANGLE_STEP: assert property (@(posedge clk) disable iff (rst)
      upd |=> angle == $past(angle) + phase_t'($past(step))); // R5
   AST_ANGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(angle)); // R10
endmodule

// File: rtl/grid_sync_estimator.sv
module grid_sync_estimator
   import gse_pkg::*;
#(
   parameter int DW         = 16,
   parameter int ITER       = 16,
   parameter int SAMPLE_HZ  = 10000,
   parameter int GRID_HZ    = 50,
   parameter int FDEV_HZ    = 10,
   parameter int DELAY_N    = 12,
   parameter int KP_Q       = 3257,
   parameter int KP_SHIFT   = 16,
   parameter int KI_Q       = 17169,
   parameter int KI_SHIFT   = 24,
   parameter int AMP_RECIP  = 15825,
   parameter int AMP_SHIFT  = 12,
   parameter int AW         = DW + 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sample_valid,
   input  logic signed [DW-1:0] d_in,
   input  logic signed [DW-1:0] q_in,
   output logic                 est_valid,
   output logic [31:0]          angle,
   output logic [31:0]          angle_corr,
   output logic signed [31:0]   freq,
   output logic signed [AW-1:0] amplitude
);
   localparam longint NOM_L  = (longint'(GRID_HZ) <<< 32) / SAMPLE_HZ;
   localparam longint LIM_L  = (longint'(FDEV_HZ) <<< 32) / SAMPLE_HZ;
   localparam longint CORR_L = ((64'sd1 <<< 32) / (2 * DELAY_N)) - (64'sd1 <<< 30);
   localparam phase_t CORR_W = phase_t'(CORR_L);

   if (DELAY_N < 2 || SAMPLE_HZ <= 2 * GRID_HZ) begin : g_bad_cfg
      $error("grid_sync_estimator: delay factor or sample rate out of range");
   end
   if (longint'(AMP_RECIP) >= (64'sd1 <<< (AMP_SHIFT + AW - DW - 1))) begin : g_bad_amp
      $error("grid_sync_estimator: AW too narrow for AMP_RECIP");
   end

   logic                 busy, done;
   phase_t               z;
   logic signed [DW-1:0] d_hold;
   logic signed [31:0]   freq_next;

   gse_cordic_vec #(.DW(DW), .ITER(ITER)) i_cordic (
      .clk(clk), .rst(rst), .start(sample_valid),
      .x_in(d_in), .y_in(q_in),
      .busy(busy), .done(done), .z_out(z)
   );

   gse_pi_ctrl #(
      .NOM(int'(NOM_L)), .LIM(int'(LIM_L)),
      .KP_Q(KP_Q), .KP_SHIFT(KP_SHIFT), .KI_Q(KI_Q), .KI_SHIFT(KI_SHIFT)
   ) i_pi (
      .clk(clk), .rst(rst), .upd(done), .err(signed'(z)),
      .freq_next(freq_next), .freq(freq)
   );

   gse_phase_acc #(.CORR(CORR_W)) i_acc (
      .clk(clk), .rst(rst), .upd(done), .step(freq_next),
      .angle(angle), .angle_corr(angle_corr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         d_hold    <= '0;
         amplitude <= '0;
         est_valid <= 1'b0;
      end else begin
         est_valid <= done;
         if (sample_valid && !busy)
            d_hold <= d_in;
         if (done)
            amplitude <= AW'((longint'(d_hold) * longint'(AMP_RECIP)) >>> AMP_SHIFT);
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      est_valid |=> !est_valid); // R8
   AST_AMP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !est_valid |-> $stable(amplitude)); // R10
endmodule

// File: tb/test_grid_sync_estimator.sv
module test_grid_sync_estimator;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16, AW = 20, N_DELAY = 12, FS = 10000, FG = 50, FDEV = 10;
   localparam int KPQ = 3257, KPS = 16, KIQ = 17169, KIS = 24, RECIP = 15825, RSH = 12;
   localparam int LAT = 17;
   localparam longint NOM = (longint'(FG) <<< 32) / FS;
   localparam longint LIM = (longint'(FDEV) <<< 32) / FS;
   localparam logic [31:0] CORR = 32'(((64'sd1 <<< 32) / (2 * N_DELAY)) - (64'sd1 <<< 30));

   logic clk = 1'b0;
   logic rst;
   logic sample_valid;
   logic signed [DW-1:0] d_in, q_in;
   logic est_valid;
   logic [31:0] angle, angle_corr;
   logic signed [31:0] freq;
   logic signed [AW-1:0] amplitude;

   always #(CLK_PERIOD/2) clk = ~clk;

   grid_sync_estimator i_grid_sync_estimator (
      .clk(clk), .rst(rst), .sample_valid(sample_valid), .d_in(d_in), .q_in(q_in),
      .est_valid(est_valid), .angle(angle), .angle_corr(angle_corr),
      .freq(freq), .amplitude(amplitude)
   );

   int total = 0, bad = 0;
   int n_sent = 0, n_done = 0, n_upd = 0;
   longint cyc = 0;
   longint i_m = 0;
   logic [31:0] prev_angle = '0;
   bit wrap_seen = 1'b0;
   bit finished = 1'b0;
   longint q_err[$], q_amp[$], q_edge[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint labs(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      longint e, a, ed, pm, im_n, fm, tol;
      logic [31:0] exp_ang;
      if (!rst && est_valid) begin
         if (q_err.size() == 0) begin
            chk(1'b0, "R9", "result without accepted sample", 1, 0);
         end else begin
            e  = q_err.pop_front();
            a  = q_amp.pop_front();
            ed = q_edge.pop_front();
            chk(cyc == ed + LAT, "R8", "latency", cyc - ed, LAT);
            chk(longint'(amplitude) == a, "R7", "amplitude", longint'(amplitude), a);
            pm   = (e * KPQ) >>> KPS;
            im_n = i_m + ((e * KIQ) >>> KIS);
            if (im_n > LIM) im_n = LIM;
            if (im_n < -LIM) im_n = -LIM;
            i_m = im_n;
            n_upd++;
            fm  = NOM + i_m + pm;
            tol = 3000 + 60 * n_upd;
            chk(labs(longint'(freq) - fm) <= tol, "R2/R3", "freq", longint'(freq), fm);
            exp_ang = prev_angle + 32'(freq);
            chk(angle == exp_ang, "R5", "angle", longint'(angle), longint'(exp_ang));
            chk(angle_corr == angle + CORR, "R6", "angle_corr",
                longint'(angle_corr), longint'(angle + CORR));
            if (angle < prev_angle && freq > 0) wrap_seen = 1'b1;
            prev_angle = angle;
         end
         n_done++;
      end
   end

   // driver: one sample, optional extra strobes inside the busy window
   task automatic send(input int d, input int q, input bit junk);
      real r;
      @(negedge clk);
      d_in = DW'(d);
      q_in = DW'(q);
      sample_valid = 1'b1;
      r = $atan2(real'(q), real'(d)) / (2.0 * 3.14159265358979) * 4294967296.0;
      q_err.push_back(longint'(r));
      q_amp.push_back((longint'(d) * RECIP) >>> RSH);
      q_edge.push_back(cyc + 1);
      n_sent++;
      @(negedge clk);
      sample_valid = 1'b0;
      if (junk) begin
         repeat (3) @(negedge clk);
         d_in = -16'sd20000;
         q_in = 16'sd12000;
         sample_valid = 1'b1;
         repeat (6) @(negedge clk);
         sample_valid = 1'b0;
      end
      wait (n_done == n_sent);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      i_m = 0;
      n_upd = 0;
      prev_angle = '0;
      rst = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] s_ang;
      logic signed [31:0] s_frq;
      logic signed [AW-1:0] s_amp;
      longint p90;
      rst = 1'b1;
      sample_valid = 1'b0;
      d_in = '0;
      q_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(angle == 32'd0, "R1", "angle", longint'(angle), 0);
      chk(longint'(freq) == NOM, "R1", "freq", longint'(freq), NOM);
      chk(angle_corr == CORR, "R1", "angle_corr", longint'(angle_corr), longint'(CORR));
      chk(amplitude == '0, "R1", "amplitude", longint'(amplitude), 0);
      chk(est_valid == 1'b0, "R1", "est_valid", longint'(est_valid), 0);

      // R2 all four quadrants and the +q axis
      send(12000, 3000, 1'b0);
      send(-9000, 7000, 1'b0);
      send(-10000, -6000, 1'b0);
      send(8000, -11000, 1'b0);
      send(0, 9000, 1'b0);
      send(15000, -400, 1'b0);

      // R4 positive then negative saturation
      do_reset();
      p90 = ((64'sd1 <<< 30) * KPQ) >>> KPS;
      for (int k = 0; k < 12; k++) send(0, 15000, 1'b0);
      chk(labs(longint'(freq) - (NOM + LIM + p90)) <= 3000, "R4", "freq at +limit",
          longint'(freq), NOM + LIM + p90);
      for (int k = 0; k < 30; k++) send(0, -15000, 1'b0);
      chk(labs(longint'(freq) - (NOM - LIM - p90)) <= 3000, "R4", "freq at -limit",
          longint'(freq), NOM - LIM - p90);

      // R9 strobes during a conversion, R10 hold between updates
      do_reset();
      send(10000, 500, 1'b1);
      send(-7000, -300, 1'b1);
      s_ang = angle;
      s_frq = freq;
      s_amp = amplitude;
      repeat (10) @(negedge clk);
      chk(angle == s_ang, "R10", "angle hold", longint'(angle), longint'(s_ang));
      chk(freq == s_frq, "R10", "freq hold", longint'(freq), longint'(s_frq));
      chk(amplitude == s_amp, "R10", "amplitude hold", longint'(amplitude), longint'(s_amp));
      chk(n_done == n_sent && q_err.size() == 0, "R9", "result count",
          n_done, n_sent);

      // R5 wrap of the phase word
      do_reset();
      wrap_seen = 1'b0;
      for (int k = 0; k < 215; k++) send(15000, 0, 1'b0);
      chk(wrap_seen, "R5", "angle wrapped", longint'(wrap_seen), 1);

      summary();
   end
endmodule